// File: doc/BRIEF.md
# Maskable Interrupt Recognition Timing Unit

This block reproduces, cycle by cycle, when a small 8-bit processor core notices a maskable interrupt request and starts to service it. It does not decode opcodes. An instruction sequencer outside the block hands it one descriptor per instruction: the length in cycles, whether the instruction is a conditional branch, and whether that branch is taken. The block then works out which cycle of each instruction looks at the interrupt request. It decides at each instruction boundary whether the next thing to run is the interrupt entry sequence, and it marks the cycles of that sequence.

The active-low request line is sampled once per cycle. A low level becomes visible to the instruction logic one cycle later, through a pending flag. Ordinary instructions look at that flag in their final cycle. Conditional branches always look at it in their second cycle, so the third cycle of a taken branch cannot see a request. As a result, the time from assertion to service is anywhere from 2 to 10 cycles. An internal interrupt-disable flag blocks the decision. For test, a counter measures how many cycles pass from the falling edge of the request to the first cycle of the entry sequence.

Top module: `irq_recog_unit`

## Requirements
- R1: After reset, `ins_ready` is 1, `take_irq` and `entry_active` are 0, `imask` is 1 and `lat_valid` is 0.
- R2: A request first driven low in the final cycle of an ordinary instruction is not seen by that instruction. Service starts after the next instruction ends, so the latency is 1 plus that next instruction's length.
- R3: A request driven low in the second-to-last cycle of an ordinary instruction is serviced right after that instruction, giving the minimum latency of 2 cycles.
- R4: An ordinary instruction of length L (2 to 8 cycles) polls only in cycle L. A request raised in its first cycle gives a latency of L.
- R5: A branch (`ins_branch`=1) lasts 2 cycles when `ins_taken`=0 and 3 cycles when `ins_taken`=1, ignoring `ins_len`. It polls in its second cycle. A request in cycle 1 gives latency 2 (not taken) or 3 (taken). A request in cycle 2 of a taken branch waits for the whole following instruction.
- R6: A request raised in cycle 2 of a taken branch that is followed by an 8-cycle instruction gives the maximum latency of 10 cycles.
- R7: A grant produces one `take_irq` pulse in the last cycle of the polling instruction. It is followed by exactly 7 cycles of `entry_active`, with `entry_step` counting 1 to 7, during which `ins_ready` is 0.
- R8: While `imask` is 1 no interrupt is taken, even with the request held low. `imask_clr` clears it and `imask_set` sets it. The block sets it itself after entry step 7.
- R9: The request is level sensitive. A request released before its instruction polls is lost, and no entry sequence follows.
- R10: `lat_cycles` restarts at 1 in the cycle after a falling edge of `irq_n` and counts up each cycle, saturating at its maximum. It freezes in entry step 1, and `lat_valid` is 1 from the next cycle until the next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Descriptor present; accepted in a cycle where `ins_ready` is 1, which becomes cycle 1 of the instruction |
| ins_len | input | 4 | Total cycles of an ordinary instruction (2 to 8; below 2 treated as 2) |
| ins_branch | input | 1 | Instruction is a conditional branch |
| ins_taken | input | 1 | Branch is taken |
| irq_n | input | 1 | Active-low maskable interrupt request |
| imask_set | input | 1 | Set the interrupt-disable flag |
| imask_clr | input | 1 | Clear the interrupt-disable flag (loses to a set) |
| ins_ready | output | 1 | An instruction may start in this cycle |
| take_irq | output | 1 | Interrupt granted; high in the last cycle of the polling instruction |
| entry_active | output | 1 | Interrupt entry sequence in progress |
| entry_step | output | 3 | Entry sequence cycle number, 1 to 7; 0 when idle |
| imask | output | 1 | Interrupt-disable flag |
| lat_cycles | output | 5 | Measured latency from request edge to entry start |
| lat_valid | output | 1 | `lat_cycles` holds a completed measurement |

## Verification
A pending flag that takes the line without its one-cycle delay shows up as a latency one cycle too short. A fault in which cycle is polled, such as a branch that polls in its last cycle or an instruction that polls in its first, moves the entry start by one or more instruction lengths. Both errors are visible on `lat_cycles` as soon as the entry sequence begins. A fault in the entry counter or the mask update shows up within seven cycles as a wrong entry length, an `ins_ready` that rises during entry, or a request that is serviced twice or while masked.

// File: rtl/irq_timing_pkg.sv
package irq_timing_pkg;
  localparam int DEF_LEN_W        = 4;  // wide enough for 8-cycle instructions
  localparam int DEF_ENTRY_CYCLES = 7;  // entry sequence length
  localparam int DEF_LAT_W        = 5;  // latency meter width
  localparam int BRANCH_POLL_CYC  = 2;  // branches poll in this cycle
  localparam int BRANCH_BASE_LEN  = 2;  // not-taken branch length
  localparam int MIN_INS_LEN      = 2;  // shortest instruction
endpackage

// File: rtl/irq_line_sampler.sv
module irq_line_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_n,
  output logic pend,
  output logic irq_fall
);
  logic line_q;
  logic pend_d;
  logic line_d;

  always_comb begin
    pend_d   = ~irq_n;
    line_d   = irq_n;
    irq_fall = line_q & ~irq_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      line_q <= 1'b1;
    end else begin
      pend   <= pend_d;
      line_q <= line_d;
    end
  end
endmodule

// File: rtl/ins_cycle_tracker.sv
module ins_cycle_tracker
  import irq_timing_pkg::*;
#(
  parameter int LEN_W = DEF_LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [LEN_W-1:0] len_in,
  input  logic             branch_in,
  input  logic             taken_in,
  output logic             busy,
  output logic             poll_now,
  output logic             last_now
);
  logic [LEN_W-1:0] pos_q, pos_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [LEN_W-1:0] pol_q, pol_d;
  logic             busy_d;
  logic [LEN_W-1:0] eff_len, eff_poll;
  logic [LEN_W-1:0] cur_pos, cur_len, cur_pol;
  logic             active;

  always_comb begin
    if (branch_in) begin
      eff_len  = taken_in ? LEN_W'(BRANCH_BASE_LEN + 1) : LEN_W'(BRANCH_BASE_LEN);
      eff_poll = LEN_W'(BRANCH_POLL_CYC);
    end else begin
      eff_len  = (len_in < LEN_W'(MIN_INS_LEN)) ? LEN_W'(MIN_INS_LEN) : len_in;
      eff_poll = eff_len;
    end
    active   = accept | busy;
    cur_pos  = accept ? LEN_W'(1) : pos_q;
    cur_len  = accept ? eff_len   : len_q;
    cur_pol  = accept ? eff_poll  : pol_q;
    poll_now = active & (cur_pos == cur_pol);
    last_now = active & (cur_pos == cur_len);
    busy_d   = active & ~last_now;
    pos_d    = active ? cur_pos + LEN_W'(1) : pos_q;
    len_d    = accept ? eff_len  : len_q;
    pol_d    = accept ? eff_poll : pol_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      pos_q <= '0;
      len_q <= '0;
      pol_q <= '0;
    end else begin
      busy  <= busy_d;
      pos_q <= pos_d;
      len_q <= len_d;
      pol_q <= pol_d;
    end
  end
endmodule

// File: rtl/entry_sequencer.sv
module entry_sequencer #(
  parameter int ENTRY_CYCLES = 7,
  parameter int STEP_W       = $clog2(ENTRY_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              active,
  output logic [STEP_W-1:0] step,
  output logic              first,
  output logic              done
);
  logic [STEP_W-1:0] step_d;

  always_comb begin
    active = (step != '0);
    first  = (step == STEP_W'(1));
    done   = (step == STEP_W'(ENTRY_CYCLES));
    if (start)
      step_d = STEP_W'(1);
    else if (active)
      step_d = done ? '0 : step + STEP_W'(1);
    else
      step_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step <= '0;
    else        step <= step_d;
  end
endmodule

// File: rtl/latency_meter.sv
module latency_meter #(
  parameter int LAT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_evt,
  input  logic             stop_evt,
  output logic [LAT_W-1:0] count,
  output logic             valid
);
  logic             run_q, run_d;
  logic [LAT_W-1:0] count_d;
  logic             valid_d;

  always_comb begin
    run_d   = run_q;
    count_d = count;
    valid_d = valid;
    if (start_evt) begin
      run_d   = 1'b1;
      count_d = LAT_W'(1);
      valid_d = 1'b0;
    end else if (run_q && stop_evt) begin
      run_d   = 1'b0;
      valid_d = 1'b1;
    end else if (run_q && (count != '1)) begin
      count_d = count + LAT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      count <= '0;
      valid <= 1'b0;
    end else begin
      run_q <= run_d;
      count <= count_d;
      valid <= valid_d;
    end
  end
endmodule

// File: rtl/irq_recog_unit.sv
module irq_recog_unit
  import irq_timing_pkg::*;
#(
  parameter int LEN_W        = DEF_LEN_W,
  parameter int ENTRY_CYCLES = DEF_ENTRY_CYCLES,
  parameter int LAT_W        = DEF_LAT_W,
  parameter int STEP_W       = $clog2(ENTRY_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [LEN_W-1:0]  ins_len,
  input  logic              ins_branch,
  input  logic              ins_taken,
  input  logic              irq_n,
  input  logic              imask_set,
  input  logic              imask_clr,
  output logic              ins_ready,
  output logic              take_irq,
  output logic              entry_active,
  output logic [STEP_W-1:0] entry_step,
  output logic              imask,
  output logic [LAT_W-1:0]  lat_cycles,
  output logic              lat_valid
);
  logic pend, irq_fall;
  logic busy, poll_now, last_now;
  logic accept, poll_grant;
  logic grant_q, grant_d;
  logic imask_d;
  logic entry_first, entry_done;

  irq_line_sampler u_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_n    (irq_n),
    .pend     (pend),
    .irq_fall (irq_fall)
  );

  ins_cycle_tracker #(.LEN_W(LEN_W)) u_tracker (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .len_in    (ins_len),
    .branch_in (ins_branch),
    .taken_in  (ins_taken),
    .busy      (busy),
    .poll_now  (poll_now),
    .last_now  (last_now)
  );

  entry_sequencer #(.ENTRY_CYCLES(ENTRY_CYCLES), .STEP_W(STEP_W)) u_entry (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (take_irq),
    .active (entry_active),
    .step   (entry_step),
    .first  (entry_first),
    .done   (entry_done)
  );

  latency_meter #(.LAT_W(LAT_W)) u_lat (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_evt (irq_fall),
    .stop_evt  (entry_first),
    .count     (lat_cycles),
    .valid     (lat_valid)
  );

  always_comb begin
    ins_ready  = ~busy & ~entry_active;
    accept     = ins_ready & ins_valid;
    poll_grant = poll_now & pend & ~imask;
    take_irq   = last_now & (grant_q | poll_grant);
    grant_d    = last_now ? 1'b0 : (grant_q | poll_grant);
    if (entry_done || imask_set)
      imask_d = 1'b1;
    else if (imask_clr)
      imask_d = 1'b0;
    else
      imask_d = imask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= 1'b0;
      imask   <= 1'b1;
    end else begin
      grant_q <= grant_d;
      imask   <= imask_d;
    end
  end
endmodule

// File: rtl/irq_recog_checker.sv
module irq_recog_checker #(
  parameter int ENTRY_CYCLES = 7,
  parameter int STEP_W       = 3,
  parameter int LAT_W        = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ins_ready,
  input logic              take_irq,
  input logic              entry_active,
  input logic [STEP_W-1:0] entry_step,
  input logic              imask,
  input logic [LAT_W-1:0]  lat_cycles,
  input logic              lat_valid
);
  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    entry_active |-> (entry_step >= STEP_W'(1) && entry_step <= STEP_W'(ENTRY_CYCLES))); // R7
  AST_READY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    entry_active |-> !ins_ready); // R7
  AST_TAKE_STARTS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> (entry_active && entry_step == STEP_W'(1))); // R7
  AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> !take_irq); // R7
  AST_MASK_AFTER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_active && entry_step == STEP_W'(ENTRY_CYCLES)) |=> imask); // R8
  AST_LAT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lat_valid) |-> (lat_cycles >= LAT_W'(2))); // R3
endmodule

bind irq_recog_unit irq_recog_checker #(
  .ENTRY_CYCLES (ENTRY_CYCLES),
  .STEP_W       (STEP_W),
  .LAT_W        (LAT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ins_ready    (ins_ready),
  .take_irq     (take_irq),
  .entry_active (entry_active),
  .entry_step   (entry_step),
  .imask        (imask),
  .lat_cycles   (lat_cycles),
  .lat_valid    (lat_valid)
);

// File: tb/irq_recog_unit_tb.sv
module irq_recog_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ins_valid, ins_branch, ins_taken, irq_n, imask_set, imask_clr;
  logic [3:0] ins_len;
  logic       ins_ready, take_irq, entry_active, imask, lat_valid;
  logic [2:0] entry_step;
  logic [4:0] lat_cycles;

  int checks   = 0;
  int failures = 0;
  int cyc      = 0;
  int take_cnt = 0;
  int entry_cnt = 0;
  int overlap_cnt = 0;

  always #10 clk = ~clk;

  irq_recog_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_len(ins_len),
    .ins_branch(ins_branch), .ins_taken(ins_taken), .irq_n(irq_n),
    .imask_set(imask_set), .imask_clr(imask_clr), .ins_ready(ins_ready),
    .take_irq(take_irq), .entry_active(entry_active), .entry_step(entry_step),
    .imask(imask), .lat_cycles(lat_cycles), .lat_valid(lat_valid)
  );

  always @(negedge clk) begin
    #5;
    if (take_irq) take_cnt++;
    if (entry_active) entry_cnt++;
    if (entry_active && ins_ready) overlap_cnt++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_counts();
    take_cnt = 0; entry_cnt = 0; overlap_cnt = 0;
  endtask

  task automatic clr_mask();
    @(negedge clk); imask_clr = 1'b1;
    @(negedge clk); imask_clr = 1'b0;
    clear_counts();
  endtask

  // run one instruction; irq driven low in cycle irq_at, high again in cycle irq_off (0 = never)
  task automatic issue(input int len, input bit br, input bit tk, input int irq_at, input int irq_off);
    int eff;
    eff = br ? (tk ? 3 : 2) : len;
    @(negedge clk);
    while (!ins_ready) @(negedge clk);
    ins_valid = 1'b1; ins_len = 4'(len); ins_branch = br; ins_taken = tk;
    if (irq_at == 1) irq_n = 1'b0;
    for (int c = 2; c <= eff; c++) begin
      @(negedge clk);
      ins_valid = 1'b0;
      if (c == irq_at)  irq_n = 1'b0;
      if (c == irq_off) irq_n = 1'b1;
    end
  endtask

  task automatic wait_entry(input int exp_lat, input string tag);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (entry_active) irq_n = 1'b1;
    end
    #6;
    if (exp_lat >= 0) begin
      chk({tag, " lat_valid"}, lat_valid, 1);
      chk({tag, " lat_cycles"}, lat_cycles, exp_lat);
    end
    chk("R7 entry length", entry_cnt, 7);
    chk("R7 single take", take_cnt, 1);
    chk("R7 ready low in entry", overlap_cnt, 0);
    chk("R8 mask set after entry", imask, 1);
  endtask

  task automatic t_reset();
    chk("R1 ins_ready", ins_ready, 1);
    chk("R1 take_irq", take_irq, 0);
    chk("R1 entry_active", entry_active, 0);
    chk("R1 imask", imask, 1);
    chk("R1 lat_valid", lat_valid, 0);
  endtask

  task automatic t_masked();
    clear_counts();
    issue(3, 0, 0, 1, 0);
    issue(4, 0, 0, 0, 0);
    repeat (5) @(negedge clk);
    #6;
    chk("R8 masked no entry", entry_cnt, 0);
    chk("R8 masked no take", take_cnt, 0);
    clr_mask();
    issue(2, 0, 0, 0, 0);
    wait_entry(-1, "R8");
  endtask

  task automatic t_best();
    clr_mask();
    issue(4, 0, 0, 3, 0);
    wait_entry(2, "R3 best case");
  endtask

  task automatic t_full_len();
    clr_mask();
    issue(8, 0, 0, 1, 0);
    wait_entry(8, "R4 poll in last cycle");
  endtask

  task automatic t_last_missed();
    clr_mask();
    issue(3, 0, 0, 3, 0);
    issue(5, 0, 0, 0, 0);
    wait_entry(6, "R2 last cycle missed");
  endtask

  task automatic t_branches();
    clr_mask();
    issue(7, 1, 0, 1, 0);
    wait_entry(2, "R5 branch not taken");
    clr_mask();
    issue(7, 1, 1, 1, 0);
    wait_entry(3, "R5 branch taken early");
    clr_mask();
    issue(2, 1, 1, 2, 0);
    issue(2, 0, 0, 0, 0);
    wait_entry(4, "R5 branch taken late");
  endtask

  task automatic t_worst();
    clr_mask();
    issue(2, 1, 1, 2, 0);
    issue(8, 0, 0, 0, 0);
    wait_entry(10, "R6 worst case");
  endtask

  task automatic t_lost();
    clr_mask();
    issue(6, 0, 0, 1, 3);
    repeat (15) @(negedge clk);
    #6;
    chk("R9 lost no entry", entry_cnt, 0);
    chk("R9 lost no take", take_cnt, 0);
    chk("R9 ready after lost", ins_ready, 1);
    chk("R10 no measurement", lat_valid, 0);
  endtask

  initial begin
    rst_n = 1'b0; ins_valid = 1'b0; ins_len = 4'd2; ins_branch = 1'b0;
    ins_taken = 1'b0; irq_n = 1'b1; imask_set = 1'b0; imask_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_masked();
    t_best();
    t_full_len();
    t_last_missed();
    t_branches();
    t_worst();
    t_lost();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule